// File: doc/BRIEF.md
# Chainable FIFO Slice with Token Hand-off

This block is one slice of a first-in first-out queue, nine bits wide by default. It can work in two modes. In standalone mode it is an ordinary FIFO. It has empty and full flags, a flag that shows it holds more than half its depth, and a retransmit control that replays the stored data from the first location. In chained mode, several identical slices sit on the same write strobe, read strobe and data bus and act as one deeper queue. A write token and a read token pass from slice to slice around a ring. Only the slice that holds the write token stores the next word. Only the slice that holds the read token presents the head word. So each word is held in exactly one slice, and a hand-off adds no dead cycle.

The dual-purpose input `first_load_rt` has a different job in each mode. In chained mode it is a strap: low marks the master slice, which holds both tokens after reset. In standalone mode it is the retransmit request. The expansion output works the same way. In chained mode it carries the token pulses. In standalone mode it carries the half-full flag. The slice uses one clock, and the strobes are synchronous enables. In chained mode, the board-level queue outputs are the OR of every slice's `dout`, `empty` and `full`. A slice that does not own the relevant token drives each of these low.

Top module: `chain_fifo_slice`

## Requirements
- R1: While `rst` is high on a clock edge, both pointers and the word count go to zero. After that edge the slice reports `empty`=1, `full`=0 and `xo_hf`=2'b00. Data stored before the reset is lost.
- R2: In standalone mode (`chain_en`=0), words leave in the order they were written. `dout` shows the oldest word whenever `empty` is 0. `empty` is 1 exactly when the count is 0, and `full` is 1 exactly when the count equals DEPTH.
- R3: A write strobe while `full` is 1 is ignored, and so is a read strobe while `empty` is 1. The ignored strobe changes no pointer and no count.
- R4: In standalone mode, `xo_hf[0]` is 1 exactly when the stored word count is greater than DEPTH/2, and `xo_hf[1]` is 0.
- R5: In standalone mode, `first_load_rt`=1 on a clock edge moves only the read pointer back to location 0. The write pointer stays where it is, and the count becomes the write pointer value. Read and write strobes in that cycle are ignored.
- R6: In chained mode, after reset a slice with `first_load_rt`=0 owns both tokens, and a slice with `first_load_rt`=1 owns neither. A slice without the read token drives `dout`=0 and `empty`=0. A slice without the write token drives `full`=0.
- R7: In chained mode, when a slice writes its last location (DEPTH-1), its write pointer wraps to 0 and it gives up the write token. It also raises `xo_hf[0]` for exactly the next cycle. A slice that sees `xi[0]`=1 owns the write token in that same cycle and keeps it afterwards.
- R8: The read token moves in the same way. Reading location DEPTH-1 wraps the read pointer, releases the token and raises `xo_hf[1]` for one cycle. The next slice owns the token while it sees `xi[1]`=1 and keeps it afterwards.
- R9: N slices whose expansion outputs feed the next slice's `xi` in a ring behave as one FIFO of N*DEPTH words. Across every hand-off, each word comes out once and in write order, and no cycle is lost.
- R10: In chained mode there is no half-full flag and no retransmit. `xo_hf` is 0 except for hand-off pulses, and `first_load_rt` only selects the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chain_en | input | 1 | Mode strap: 1 = chained, 0 = standalone |
| first_load_rt | input | 1 | Chained mode: 0 = master strap. Standalone mode: retransmit request |
| wr_en | input | 1 | Write strobe, shared by all chained slices |
| rd_en | input | 1 | Read strobe, shared by all chained slices |
| din | input | DATA_W | Write data |
| xi | input | 2 | Token pulses from the previous slice: bit 0 write token, bit 1 read token |
| dout | output | DATA_W | Head word (0 when this slice does not own the read token) |
| empty | output | 1 | No word is available |
| full | output | 1 | No room for a write |
| xo_hf | output | 2 | Chained mode: token pulses to the next slice. Standalone mode: bit 0 is half-full |

## Verification
The hardest state to reach is a full ring in which the write token has come back to the master while the read token is still in the master. In that state the only thing that blocks a write is the occupancy of the master's own counter. A second hard case is a hand-off cycle in which the token is held only through `xi` and not yet registered. The bench chains two four-word slices. It drives directed runs that fill the ring past a complete lap and drain it. It then runs long random stretches whose bias switches between write-heavy and read-heavy, so both tokens cross the ring many times, sometimes together and sometimes while the queue sits at full or empty.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  // Next position of a pointer that wraps after location depth-1.
  function automatic int ptr_step(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Half-full rule: strictly more than half of the depth is stored.
  function automatic bit over_half(int count, int depth);
    return count > depth / 2;
  endfunction
endpackage

// File: rtl/cfs_ptr.sv
module cfs_ptr #(
  parameter int DEPTH = 2048,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          clr,
  output logic [PW-1:0] ptr,
  output logic          at_last
);
  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (adv)   ptr <= PW'(cfs_pkg::ptr_step(int'(ptr), DEPTH));
  end

  assign at_last = (ptr == PW'(DEPTH - 1));
endmodule

// File: rtl/cfs_store.sv
module cfs_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cfs_owner.sv
module cfs_owner (
  input  logic clk,
  input  logic rst,
  input  logic chain_en,
  input  logic is_master,
  input  logic tok_in,
  input  logic last_use,
  output logic own,
  output logic pulse
);
  logic tok_q, pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q   <= chain_en && is_master;
      pulse_q <= 1'b0;
    end else begin
      tok_q   <= chain_en && !last_use && (tok_q || tok_in);
      pulse_q <= chain_en && last_use;
    end
  end

  // A token arriving on tok_in is usable in the same cycle.
  assign own   = !chain_en || tok_q || tok_in;
  assign pulse = pulse_q;
endmodule

// File: rtl/chain_fifo_slice.sv
module chain_fifo_slice #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chain_en,
  input  logic              first_load_rt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        xi,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic [1:0]        xo_hf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rdata;
  logic own_w, own_r, wr_fire, rd_fire, wr_at_last, rd_at_last;
  logic wr_last, rd_last, hand_w, hand_r, cnt_full, cnt_zero, half_flag, rt_req;

  assign rt_req   = !chain_en && first_load_rt;
  assign cnt_full = (cnt == CW'(DEPTH));
  assign cnt_zero = (cnt == '0);
  assign wr_fire  = wr_en && own_w && !cnt_full && !rt_req;
  assign rd_fire  = rd_en && own_r && !cnt_zero && !rt_req;
  assign wr_last  = wr_fire && wr_at_last;
  assign rd_last  = rd_fire && rd_at_last;

  cfs_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .adv(wr_fire), .clr(1'b0),
    .ptr(wr_ptr), .at_last(wr_at_last)
  );

  cfs_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst(rst), .adv(rd_fire), .clr(rt_req),
    .ptr(rd_ptr), .at_last(rd_at_last)
  );

  cfs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(din),
    .raddr(rd_ptr), .rdata(rdata)
  );

  cfs_owner u_wown (
    .clk(clk), .rst(rst), .chain_en(chain_en), .is_master(!first_load_rt),
    .tok_in(xi[0]), .last_use(wr_last), .own(own_w), .pulse(hand_w)
  );

  cfs_owner u_rown (
    .clk(clk), .rst(rst), .chain_en(chain_en), .is_master(!first_load_rt),
    .tok_in(xi[1]), .last_use(rd_last), .own(own_r), .pulse(hand_r)
  );

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (rt_req) cnt <= CW'(wr_ptr);
    else             cnt <= cnt + CW'(wr_fire) - CW'(rd_fire);
  end

  assign half_flag = cfs_pkg::over_half(int'(cnt), DEPTH);
  assign full  = own_w && cnt_full;
  assign empty = own_r && cnt_zero;
  assign dout  = own_r ? rdata : '0;
  assign xo_hf = chain_en ? {hand_r, hand_w} : {1'b0, half_flag};
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int DEPTH = 2048,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          chain_en,
  input logic          first_load_rt,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          empty,
  input logic [1:0]    xo_hf,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [CW-1:0] cnt
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_write_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> (wr_ptr == $past(wr_ptr)));

  assert_read_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !(first_load_rt && !chain_en)) |=> (rd_ptr == $past(rd_ptr)));

  assert_empty_count_R2: assert property (@(posedge clk) disable iff (rst)
    empty |-> (cnt == '0));

  assert_half_full_R4: assert property (@(posedge clk) disable iff (rst)
    !chain_en |-> (xo_hf[0] == (cnt > CW'(DEPTH / 2)) && !xo_hf[1]));

  assert_retransmit_R5: assert property (@(posedge clk) disable iff (rst)
    (!chain_en && first_load_rt) |=> (rd_ptr == '0 && wr_ptr == $past(wr_ptr)));

  assert_write_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (chain_en && xo_hf[0]) |-> ($past(wr_ptr) == PW'(DEPTH - 1) && wr_ptr == '0));

  assert_read_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (chain_en && xo_hf[1]) |-> ($past(rd_ptr) == PW'(DEPTH - 1) && rd_ptr == '0));
endmodule

bind chain_fifo_slice cfs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .chain_en(chain_en), .first_load_rt(first_load_rt),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty), .xo_hf(xo_hf),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cnt(cnt)
);

// File: tb/tb_chain_fifo_slice.sv
`timescale 1ns/1ps
module tb_chain_fifo_slice;
  localparam int W = 9;
  localparam int CD = 4;       // depth of each chained slice
  localparam int CAP = 2 * CD; // ring capacity
  localparam int SD = 8;       // depth of the standalone slice

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;        // 125 MHz

  logic c_wr = 0, c_rd = 0, s_wr = 0, s_rd = 0, s_rt = 0;
  logic [W-1:0] c_din = '0, s_din = '0;
  logic [W-1:0] dout_m, dout_s, s_dout;
  logic em, es, fm, fs, s_empty, s_full;
  logic [1:0] xo_m, xo_s, s_xo;

  chain_fifo_slice #(.DATA_W(W), .DEPTH(CD)) dut (
    .clk(clk), .rst(rst), .chain_en(1'b1), .first_load_rt(1'b0),
    .wr_en(c_wr), .rd_en(c_rd), .din(c_din), .xi(xo_s),
    .dout(dout_m), .empty(em), .full(fm), .xo_hf(xo_m));

  chain_fifo_slice #(.DATA_W(W), .DEPTH(CD)) slv (
    .clk(clk), .rst(rst), .chain_en(1'b1), .first_load_rt(1'b1),
    .wr_en(c_wr), .rd_en(c_rd), .din(c_din), .xi(xo_m),
    .dout(dout_s), .empty(es), .full(fs), .xo_hf(xo_s));

  chain_fifo_slice #(.DATA_W(W), .DEPTH(SD)) solo (
    .clk(clk), .rst(rst), .chain_en(1'b0), .first_load_rt(s_rt),
    .wr_en(s_wr), .rd_en(s_rd), .din(s_din), .xi(2'b00),
    .dout(s_dout), .empty(s_empty), .full(s_full), .xo_hf(s_xo));

  wire [W-1:0] c_dout  = dout_m | dout_s;
  wire         c_empty = em | es;
  wire         c_full  = fm | fs;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // chained reference queue
  logic [W-1:0] q [16];
  int qh = 0, qn = 0;
  // standalone reference: locations, pointers, count
  logic [W-1:0] sm [SD];
  int swp = 0, srp = 0, sn = 0;

  function automatic bit hf_expect(int n);
    return n > SD / 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic peek();
    @(negedge clk); #2;
  endtask

  task automatic cstep(bit w, bit r, logic [W-1:0] d);
    int pre;
    @(negedge clk);
    c_wr = w; c_rd = r; c_din = d;
    #2;
    chk(c_empty == (qn == 0), "R9 empty", c_empty, qn == 0);
    chk(c_full == (qn == CAP), "R9 full", c_full, qn == CAP);
    if (qn > 0) chk(c_dout == q[qh], "R9 head word", c_dout, q[qh]);
    @(posedge clk);
    pre = qn;
    if (w && pre < CAP) begin q[(qh + pre) % 16] = d; qn++; end
    if (r && pre > 0) begin qh = (qh + 1) % 16; qn--; end
    #1; c_wr = 0; c_rd = 0;
  endtask

  task automatic sstep(bit w, bit r, bit rt, logic [W-1:0] d);
    int pre;
    @(negedge clk);
    s_wr = w; s_rd = r; s_rt = rt; s_din = d;
    #2;
    chk(s_empty == (sn == 0), "R2 empty", s_empty, sn == 0);
    chk(s_full == (sn == SD), "R2 full", s_full, sn == SD);
    chk(s_xo[0] == hf_expect(sn), "R4 half-full", s_xo[0], hf_expect(sn));
    if (sn > 0) chk(s_dout == sm[srp], "R2 head word", s_dout, sm[srp]);
    @(posedge clk);
    pre = sn;
    if (rt) begin srp = 0; sn = swp; end
    else begin
      if (w && pre < SD) begin sm[swp] = d; swp = (swp + 1) % SD; sn++; end
      if (r && pre > 0) begin srp = (srp + 1) % SD; sn--; end
    end
    #1; s_wr = 0; s_rd = 0; s_rt = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 / R6: state right after reset
    peek();
    chk(em == 1 && fm == 0, "R1 master flags", {em, fm}, 2'b10);
    chk(xo_m == 2'b00, "R1 expansion idle", xo_m, 0);
    chk(dout_s == 0 && es == 0 && fs == 0, "R6 slave silent", {dout_s, es, fs}, 0);

    // three words: more than half of the master, still no flag (R10)
    for (int i = 0; i < 3; i++) cstep(1, 0, W'(9'h050 + i));
    peek();
    chk(xo_m == 2'b00, "R10 no half-full in chain", xo_m, 0);

    // fourth write fills the master: write token passes (R7)
    cstep(1, 0, 9'h053);
    peek();
    chk(xo_m == 2'b01, "R7 write hand-off pulse", xo_m, 1);
    chk(fm == 0 && fs == 0, "R7 full not claimed", {fm, fs}, 0);
    peek();
    chk(xo_m == 2'b00, "R7 single-cycle pulse", xo_m, 0);

    for (int i = 0; i < 4; i++) cstep(1, 0, W'(9'h0a0 + i));
    cstep(1, 0, 9'h1ff);                  // ignored while full
    peek();
    chk(c_full == 1 && qn == CAP, "R3 write while full ignored", c_full, 1);

    // drain master: read token passes (R8)
    for (int i = 0; i < 4; i++) cstep(0, 1, '0);
    peek();
    chk(xo_m == 2'b10, "R8 read hand-off pulse", xo_m, 2);
    chk(c_dout == 9'h0a0, "R8 head after hand-off", c_dout, 9'h0a0);
    for (int i = 0; i < 4; i++) cstep(0, 1, '0);
    cstep(0, 1, '0);                      // ignored while empty
    peek();
    chk(c_empty == 1, "R3 read while empty ignored", c_empty, 1);

    // random traffic with alternating bias, many laps of both tokens (R9)
    for (int i = 0; i < 4000; i++) begin
      bit heavy_w;
      heavy_w = ((i / 37) % 2) == 0;
      cstep(($urandom % 100) < (heavy_w ? 75 : 30),
            ($urandom % 100) < (heavy_w ? 30 : 75),
            W'($urandom));
    end
    while (qn > 0) cstep(0, 1, '0);
    peek();
    chk(c_empty == 1, "R9 ring drained", c_empty, 1);

    // standalone slice
    peek();
    chk(s_empty == 1 && s_full == 0 && s_xo == 2'b00, "R1 standalone reset",
        {s_empty, s_full, s_xo}, 4'b1000);
    for (int i = 0; i < 4; i++) sstep(1, 0, 0, W'(9'h110 + i));
    peek();
    chk(s_xo[0] == 0, "R4 exactly half is not half-full", s_xo[0], 0);
    sstep(1, 0, 0, 9'h114);
    peek();
    chk(s_xo[0] == 1, "R4 half-full above half", s_xo[0], 1);
    sstep(0, 1, 0, '0);
    sstep(0, 1, 0, '0);
    sstep(1, 1, 1, 9'h1ee);               // retransmit, strobes ignored
    peek();
    chk(s_dout == 9'h110, "R5 replay from first word", s_dout, 9'h110);
    chk(s_xo[0] == 1, "R5 count restored to write pointer", s_xo[0], 1);
    for (int i = 0; i < 6; i++) sstep(0, 1, 0, '0);
    peek();
    chk(s_empty == 1, "R5 write pointer unchanged", s_empty, 1);
    for (int i = 0; i < 9; i++) sstep(1, 0, 0, W'(9'h140 + i));
    peek();
    chk(s_full == 1, "R3 standalone write while full", s_full, 1);
    for (int i = 0; i < 8; i++) sstep(0, 1, 0, '0);
    peek();
    chk(s_empty == 1, "R2 standalone drained in order", s_empty, 1);

    // reset mid-traffic discards contents (R1)
    for (int i = 0; i < 3; i++) cstep(1, 0, W'(i));
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    qn = 0; qh = 0;
    #2;
    chk(c_empty == 1 && xo_m == 0, "R1 reset discards data", c_empty, 1);
    cstep(1, 0, 9'h0cc);
    cstep(0, 1, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule